// File: doc/BRIEF.md
# Palette to DAC Index Mapper

This block sits in the pixel path of a display controller. Its input is one pixel value per clock, and its output is the 8-bit index into the colour lookup table (DAC) for that pixel. In the normal colour path, the four low bits of the pixel form an attribute. The block gates that attribute through a per-plane enable mask. It then looks the result up in a sixteen-entry table of 6-bit palette entries. Finally it builds the upper index bits from a colour-select register. Depending on a split-palette mode bit, the colour-select register either supplies bits 4 and 5 of the index or leaves them to the palette entry.

A bypass input covers the wide-pixel (256-colour) path. There the whole pixel byte becomes the index unchanged, and neither the palette nor colour select has any effect. The block also gives a registered two-bit diagnostic value. It picks two bits of the outgoing index, according to a selector field held in the plane-enable register.

Configuration goes through a small write port. Addresses 0 to 15 hold the palette entries. Address 16 is the mode register, where only bit 7 (split palette) is used. Address 17 is plane enable: bits 3:0 are the mask and bits 5:4 are the diagnostic selector. Address 18 is colour select, bits 3:0. All other addresses are ignored.

Top module: `attr_dac_mapper`

## Requirements
- R1: After reset, out_valid, dac_idx and diag_bits are all 0, every palette entry is 0, and all control registers are 0.
- R2: Attribute bit n (n = 0..3, from pix_data[n]) reaches the palette lookup only if plane-enable bit n is 1; otherwise it is replaced by 0 before the lookup.
- R3: With mode bit 7 clear, dac_idx[5:0] equals the 6-bit palette entry selected by the gated attribute.
- R4: With mode bit 7 set, dac_idx[3:0] equals bits 3:0 of the selected palette entry, and dac_idx[5:4] equals colour-select bits 1:0.
- R5: In the palette path, dac_idx[7:6] always equals colour-select bits 3:2.
- R6: When bypass is 1, dac_idx equals pix_data exactly, whatever the palette, mode, mask and colour-select contents.
- R7: diag_bits = {idx[a], idx[b]} of the index being registered, where selector (plane-enable bits 5:4) value 0 gives (a,b)=(2,0), 1 gives (5,4), 2 gives (3,1) and 3 gives (7,6).
- R8: The result for a pixel accepted with pix_valid=1 appears one clock later with out_valid=1. A cycle with pix_valid=0 gives out_valid=0 next cycle, and dac_idx and diag_bits keep their values.
- R9: A configuration write and a pixel accepted on the same clock edge use the old configuration for that pixel. Pixels accepted on later edges use the new one.
- R10: Writes to addresses 19 to 31 change no palette entry or control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 8 | Pixel value (attribute in bits 3:0) |
| bypass | input | 1 | Wide-pixel mode: pixel byte is the index |
| out_valid | output | 1 | dac_idx holds a new result |
| dac_idx | output | 8 | Registered DAC table index |
| diag_bits | output | 2 | Registered diagnostic bit pair |

## Verification
The bench goes after several corner cases, each of which a wrong design would show in a distinct way:
- Split-palette switching. A design that took bits 5:4 from the wrong source would show palette bits where colour-select bits belong.
- Partial plane masks. A mask applied after the lookup instead of before it would leak ungated palette bits.
- Bypass with hostile colour-select and palette contents. A leak would corrupt the top bits of the index.
- The exact bit order for all four diagnostic selector values, since a swapped pair is a plausible slip.
- A write landing on the same edge as a pixel, which catches a design that forwards new data too early.
- Writes to unused addresses. A sloppy decoder would alias these onto real registers.

// File: rtl/attr_map_pkg.sv
package attr_map_pkg;
  localparam int ATTR_W  = 4;
  localparam int PAL_N   = 1 << ATTR_W;
  localparam int PAL_W   = 6;
  localparam int DAC_W   = 8;
  localparam int CFG_AW  = 5;
  localparam int CFG_DW  = 8;
  localparam int CSEL_W  = 4;
  localparam int PLANE_W = 6;

  localparam logic [CFG_AW-1:0] ADDR_MODE  = CFG_AW'(PAL_N);
  localparam logic [CFG_AW-1:0] ADDR_PLANE = CFG_AW'(PAL_N + 1);
  localparam logic [CFG_AW-1:0] ADDR_CSEL  = CFG_AW'(PAL_N + 2);
  localparam int                SPLIT_BIT  = 7;

  typedef enum logic [1:0] {
    DIAG_B2_B0 = 2'd0,
    DIAG_B5_B4 = 2'd1,
    DIAG_B3_B1 = 2'd2,
    DIAG_B7_B6 = 2'd3
  } diag_sel_e;

  // zero every attribute bit whose plane is disabled
  function automatic logic [ATTR_W-1:0] f_plane_gate(
    input logic [ATTR_W-1:0] attr,
    input logic [ATTR_W-1:0] mask
  );
    return attr & mask;
  endfunction

  // build the full index from a palette entry and colour select
  function automatic logic [DAC_W-1:0] f_compose(
    input logic [PAL_W-1:0]  entry,
    input logic              split,
    input logic [CSEL_W-1:0] csel
  );
    logic [DAC_W-1:0] r;
    r[3:0] = entry[3:0];
    r[5:4] = split ? csel[1:0] : entry[5:4];
    r[7:6] = csel[3:2];
    return r;
  endfunction

  // diagnostic pair taken from the outgoing index
  function automatic logic [1:0] f_diag_pick(
    input logic [DAC_W-1:0] idx,
    input diag_sel_e        sel
  );
    logic [1:0] r;
    unique case (sel)
      DIAG_B2_B0: r = {idx[2], idx[0]};
      DIAG_B5_B4: r = {idx[5], idx[4]};
      DIAG_B3_B1: r = {idx[3], idx[1]};
      default:    r = {idx[7], idx[6]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/attr_cfg_regs.sv
module attr_cfg_regs
  import attr_map_pkg::*;
#(
  parameter int P_PAL_N  = PAL_N,
  parameter int P_PAL_W  = PAL_W,
  parameter int P_CFG_AW = CFG_AW,
  parameter int P_CFG_DW = CFG_DW
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [P_CFG_AW-1:0]             cfg_addr,
  input  logic [P_CFG_DW-1:0]             cfg_wdata,
  output logic [P_PAL_N-1:0][P_PAL_W-1:0] pal_tbl,
  output logic                            pal_split,
  output logic [PLANE_W-1:0]              plane_en,
  output logic [CSEL_W-1:0]               csel
);
  localparam int IDX_W = $clog2(P_PAL_N);

  // named decode events
  logic hit_pal, hit_mode, hit_plane, hit_csel, hit_none;
  assign hit_pal   = cfg_we && (cfg_addr < P_CFG_AW'(P_PAL_N));
  assign hit_mode  = cfg_we && (cfg_addr == ADDR_MODE);
  assign hit_plane = cfg_we && (cfg_addr == ADDR_PLANE);
  assign hit_csel  = cfg_we && (cfg_addr == ADDR_CSEL);
  assign hit_none  = cfg_we && !hit_pal && !hit_mode && !hit_plane && !hit_csel;

  logic unused_wdata_bit;
  assign unused_wdata_bit = cfg_wdata[6];

  genvar e;
  generate
    for (e = 0; e < P_PAL_N; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n)
          pal_tbl[e] <= '0;
        else if (hit_pal && cfg_addr[IDX_W-1:0] == IDX_W'(e))
          pal_tbl[e] <= cfg_wdata[P_PAL_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pal_split <= 1'b0;
      plane_en  <= '0;
      csel      <= '0;
    end else begin
      if (hit_mode)  pal_split <= cfg_wdata[SPLIT_BIT];
      if (hit_plane) plane_en  <= cfg_wdata[PLANE_W-1:0];
      if (hit_csel)  csel      <= cfg_wdata[CSEL_W-1:0];
    end
  end

  AST_CTRL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_none |=> ($stable(pal_split) && $stable(plane_en) && $stable(csel))) else $error("ctrl changed"); // R10
  AST_PAL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_none |=> $stable(pal_tbl)) else $error("palette changed"); // R10
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_pal, hit_mode, hit_plane, hit_csel, hit_none}) <= 1) else $error("decode overlap"); // R10
endmodule

// File: rtl/attr_pal_lookup.sv
module attr_pal_lookup
  import attr_map_pkg::*;
#(
  parameter int P_ATTR_W = ATTR_W,
  parameter int P_PAL_N  = PAL_N,
  parameter int P_PAL_W  = PAL_W,
  parameter int P_DAC_W  = DAC_W
) (
  input  logic [P_ATTR_W-1:0]             attr_raw,
  input  logic [P_ATTR_W-1:0]             plane_mask,
  input  logic [P_PAL_N-1:0][P_PAL_W-1:0] pal_tbl,
  input  logic                            pal_split,
  input  logic [CSEL_W-1:0]               csel,
  output logic [P_ATTR_W-1:0]             attr_gated,
  output logic [P_PAL_W-1:0]              pal_entry,
  output logic [P_DAC_W-1:0]              pal_idx
);
  assign attr_gated = f_plane_gate(attr_raw, plane_mask);
  assign pal_entry  = pal_tbl[attr_gated];
  assign pal_idx    = f_compose(pal_entry, pal_split, csel);

  always_comb begin
    AST_GATE_SUBSET: assert ((attr_gated & ~attr_raw) == '0) else $error("gate set a bit"); // R2
  end
endmodule

// File: rtl/attr_diag_mux.sv
module attr_diag_mux
  import attr_map_pkg::*;
#(
  parameter int P_DAC_W = DAC_W
) (
  input  logic [P_DAC_W-1:0] idx,
  input  logic [1:0]         sel,
  output logic [1:0]         pair
);
  assign pair = f_diag_pick(idx, diag_sel_e'(sel));
endmodule

// File: rtl/attr_dac_mapper.sv
module attr_dac_mapper
  import attr_map_pkg::*;
#(
  parameter int P_ATTR_W = ATTR_W,
  parameter int P_PAL_N  = PAL_N,
  parameter int P_PAL_W  = PAL_W,
  parameter int P_DAC_W  = DAC_W,
  parameter int P_CFG_AW = CFG_AW,
  parameter int P_CFG_DW = CFG_DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [P_CFG_AW-1:0] cfg_addr,
  input  logic [P_CFG_DW-1:0] cfg_wdata,
  input  logic                pix_valid,
  input  logic [P_DAC_W-1:0]  pix_data,
  input  logic                bypass,
  output logic                out_valid,
  output logic [P_DAC_W-1:0]  dac_idx,
  output logic [1:0]          diag_bits
);
  logic [P_PAL_N-1:0][P_PAL_W-1:0] pal_tbl;
  logic                            pal_split;
  logic [PLANE_W-1:0]              plane_en;
  logic [CSEL_W-1:0]               csel;

  attr_cfg_regs #(
    .P_PAL_N(P_PAL_N), .P_PAL_W(P_PAL_W), .P_CFG_AW(P_CFG_AW), .P_CFG_DW(P_CFG_DW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pal_tbl(pal_tbl), .pal_split(pal_split),
    .plane_en(plane_en), .csel(csel)
  );

  logic [P_ATTR_W-1:0] attr_gated;
  logic [P_PAL_W-1:0]  pal_entry;
  logic [P_DAC_W-1:0]  pal_idx;

  attr_pal_lookup #(
    .P_ATTR_W(P_ATTR_W), .P_PAL_N(P_PAL_N), .P_PAL_W(P_PAL_W), .P_DAC_W(P_DAC_W)
  ) u_lut (
    .attr_raw(pix_data[P_ATTR_W-1:0]), .plane_mask(plane_en[P_ATTR_W-1:0]),
    .pal_tbl(pal_tbl), .pal_split(pal_split), .csel(csel),
    .attr_gated(attr_gated), .pal_entry(pal_entry), .pal_idx(pal_idx)
  );

  // path select: wide pixels skip the palette entirely
  logic [P_DAC_W-1:0] next_idx;
  assign next_idx = bypass ? pix_data : pal_idx;

  logic [1:0] next_diag;
  attr_diag_mux #(.P_DAC_W(P_DAC_W)) u_diag (
    .idx(next_idx), .sel(plane_en[5:4]), .pair(next_diag)
  );

  logic accept;
  assign accept = pix_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dac_idx   <= '0;
      diag_bits <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        dac_idx   <= next_idx;
        diag_bits <= next_diag;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid) else $error("valid lost"); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!out_valid && $stable(dac_idx) && $stable(diag_bits))) else $error("idle changed output"); // R8
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bypass) |=> dac_idx == $past(pix_data)) else $error("bypass altered pixel"); // R6
  AST_TOP_FROM_CSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bypass) |=> dac_idx[7:6] == $past(csel[3:2])) else $error("top bits wrong"); // R5
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bypass && plane_en[3:0] == 4'h0 && !pal_split)
      |=> dac_idx[5:0] == $past(pal_tbl[0])) else $error("mask leak"); // R2
endmodule

// File: tb/attr_dac_mapper_test.sv
module attr_dac_mapper_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [4:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       pix_valid;
  logic [7:0] pix_data;
  logic       bypass;
  logic       out_valid;
  logic [7:0] dac_idx;
  logic [1:0] diag_bits;

  always #10 clk = ~clk;

  attr_dac_mapper uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
    .bypass(bypass), .out_valid(out_valid), .dac_idx(dac_idx), .diag_bits(diag_bits)
  );

  int checks = 0;
  int failures = 0;

  // bench-side copy of the configuration
  logic [5:0] m_pal [16];
  logic       m_split;
  logic [5:0] m_plane;
  logic [3:0] m_csel;

  function automatic logic [7:0] exp_idx(input logic [7:0] px, input logic byp);
    logic [3:0] a;
    logic [5:0] e;
    if (byp) return px;
    a = 4'h0;
    for (int i = 0; i < 4; i++) if (m_plane[i]) a[i] = px[i];
    e = m_pal[a];
    if (m_split) return {m_csel, e[3:0]};
    return {m_csel[3:2], e};
  endfunction

  function automatic logic [1:0] exp_diag(input logic [7:0] x);
    case (m_plane[5:4])
      2'd0: return {x[2], x[0]};
      2'd1: return {x[5], x[4]};
      2'd2: return {x[3], x[1]};
      default: return {x[7], x[6]};
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic void model_write(input logic [4:0] a, input logic [7:0] d);
    if (a < 16) m_pal[a[3:0]] = d[5:0];
    else if (a == 16) m_split = d[7];
    else if (a == 17) m_plane = d[5:0];
    else if (a == 18) m_csel = d[3:0];
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic pix(input string tag, input logic [7:0] px, input logic byp);
    logic [7:0] e;
    @(negedge clk);
    pix_valid = 1'b1; pix_data = px; bypass = byp;
    e = exp_idx(px, byp);
    @(negedge clk);
    pix_valid = 1'b0;
    chk({tag, " valid"}, int'(out_valid), 1);
    chk({tag, " idx"}, int'(dac_idx), int'(e));
    chk({tag, " diag"}, int'(diag_bits), int'(exp_diag(e)));
  endtask

  initial begin
    int unsigned seed;
    logic [7:0] held;
    logic [7:0] e;
    logic [4:0] ra;
    logic [7:0] rd;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pix_valid = 1'b0; pix_data = '0; bypass = 1'b0;
    for (int i = 0; i < 16; i++) m_pal[i] = '0;
    m_split = 1'b0; m_plane = '0; m_csel = '0;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at ports, and zeroed configuration seen through a pixel
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 idx", int'(dac_idx), 0);
    chk("R1 diag", int'(diag_bits), 0);
    m_plane = 6'h0f;
    wr(5'd17, 8'h0f);
    pix("R1 zero palette", 8'h0b, 1'b0);

    // load palette with distinct values
    for (int i = 0; i < 16; i++) wr(5'(i), 8'(8'h30 ^ (i * 5)));
    wr(5'd18, 8'h0e);
    // R3 full mask, split off
    for (int i = 0; i < 16; i++) pix("R3 lookup", 8'(i | 8'ha0), 1'b0);
    // R2 partial masks
    wr(5'd17, 8'h05);
    pix("R2 mask 0101", 8'h0f, 1'b0);
    wr(5'd17, 8'h0a);
    pix("R2 mask 1010", 8'h0f, 1'b0);
    wr(5'd17, 8'h00);
    pix("R2 mask none", 8'h0f, 1'b0);
    wr(5'd17, 8'h0f);
    // R4 split on
    wr(5'd16, 8'h80);
    pix("R4 split", 8'h07, 1'b0);
    wr(5'd18, 8'h05);
    pix("R4 split csel", 8'h0c, 1'b0);
    // R5 top bits follow csel in both modes
    wr(5'd18, 8'h0c);
    pix("R5 csel top split", 8'h03, 1'b0);
    wr(5'd16, 8'h7f);
    pix("R5 csel top nosplit", 8'h03, 1'b0);
    // R6 bypass with nonzero csel and palette
    wr(5'd18, 8'h0f);
    pix("R6 bypass a", 8'h5a, 1'b1);
    pix("R6 bypass b", 8'h00, 1'b1);
    pix("R6 bypass c", 8'hff, 1'b1);
    // R7 every selector value
    for (int s = 0; s < 4; s++) begin
      wr(5'd17, 8'(8'h0f | (s << 4)));
      pix("R7 sel pal", 8'h09, 1'b0);
      pix("R7 sel byp", 8'h96, 1'b1);
      pix("R7 sel byp2", 8'h69, 1'b1);
    end
    wr(5'd17, 8'h0f);
    // R8 idle cycles hold output
    pix("R8 load", 8'h3c, 1'b1);
    held = dac_idx;
    @(negedge clk);
    chk("R8 idle valid", int'(out_valid), 0);
    chk("R8 idle hold", int'(dac_idx), int'(held));
    pix_data = 8'h11;
    @(negedge clk);
    chk("R8 idle hold2", int'(dac_idx), int'(held));
    // R9 write and pixel on the same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'd5; cfg_wdata = 8'h2a;
    pix_valid = 1'b1; pix_data = 8'h05; bypass = 1'b0;
    e = exp_idx(8'h05, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0; pix_valid = 1'b0;
    chk("R9 old config", int'(dac_idx), int'(e));
    model_write(5'd5, 8'h2a);
    pix("R9 new config", 8'h05, 1'b0);
    // R10 unused addresses
    for (int a = 19; a < 32; a++) wr(5'(a), 8'hff);
    for (int i = 0; i < 16; i++) pix("R10 pal intact", 8'(i), 1'b0);
    wr(5'd17, 8'h3f);
    for (int a = 19; a < 32; a++) wr(5'(a), 8'h00);
    pix("R10 ctrl intact", 8'h0e, 1'b0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      if (($urandom() % 3) == 0) begin
        ra = 5'($urandom() % 20);
        rd = 8'($urandom());
        wr(ra, rd);
      end else begin
        pix("R3 R4 R7 random", 8'($urandom()), (($urandom() % 5) == 0));
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule